// File: doc/BRIEF.md
# Majority-vote read filter

The filter sits between a requester and a register source whose reads can come back corrupted now and then. When the requester asks for an address, the filter reads that address many times. It keeps a table of the distinct values it has seen and how often each one appeared. It returns the value that occurred most often. It stops early once one value has been seen more often than in half of the planned samples, because no other value can overtake it after that.

Reads toward the source are issued one at a time. Each read is a single-cycle strobe with an address. The source answers with a data word that is valid for one cycle, which may come some cycles later. The table search inspects one entry per clock, so a sample costs two cycles plus one cycle for each entry it passes. The requester sees a one-cycle `done_o` pulse with the filtered word. A request made while the filter is already working is dropped.

Top module: `maj_read_filter`

## Requirements
- R1: While reset is asserted and after it is released with no request, `done_o` and `src_rd_o` are low and `data_o` is zero.
- R2: A request accepted in idle latches `addr_i`. Every source read of that request carries this address on `src_addr_o`. `src_rd_o` is high for one cycle per sample, and no new read is issued until the response to the previous one has arrived on `src_valid_i`.
- R3: The returned word is the value that occurs most often among the samples taken for the request.
- R4: When several values share the top count, the returned word is the one that reached that count first, which is not necessarily the one seen first.
- R5: As soon as one value's count exceeds half of SAMPLES (51 of 100 by default), sampling stops: exactly that many reads are issued and that value is returned.
- R6: Without such a majority, exactly SAMPLES reads (100 by default) are issued before the result.
- R7: `done_o` is a single-cycle pulse, and `data_o` carries the result during that cycle only; at all other times `data_o` is zero.
- R8: A request raised while a previous one is still being processed is ignored. It produces no extra `done_o`, no extra reads and no change of the read address.
- R9: Each request starts with an empty value table and a zero running maximum, so earlier requests do not influence the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, taken only when idle |
| addr_i | input | ADDR_W | Address of the register to read |
| done_o | output | 1 | One-cycle pulse: result valid |
| data_o | output | DATA_W | Filtered read result, zero when done_o is low |
| src_rd_o | output | 1 | One-cycle read strobe toward the source |
| src_addr_o | output | ADDR_W | Address presented to the source |
| src_data_i | input | DATA_W | Source response data |
| src_valid_i | input | 1 | Source response valid, one cycle |

## Verification
The source model replays a per-request list of 100 sample words, and each list is chosen to separate one rule from another. A single constant value checks the earliest possible stop. A list of all-distinct words and an A/B alternation check the full-length run and the rule that keeps the first value seen on a tie. A repeating A,B,B,A list separates "first to reach the top count" from "first seen". Scattered noise followed by a late 51-sample run checks a majority that only appears at the last sample. Running the A/B list directly after the A,B,B,A list shows whether counts leak between requests. A request injected mid-run checks that the filter drops it.

// File: rtl/mvf_pkg.sv
package mvf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_SEARCH,
    ST_DONE
  } mvf_state_e;
endpackage

// File: rtl/mvf_table.sv
module mvf_table #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 100,
  parameter int CNT_W  = 7,
  parameter int IDX_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              new_i,
  input  logic              inc_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] rd_val_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic [IDX_W-1:0]  fill_o
);
  logic [DATA_W-1:0] val_arr [DEPTH];
  logic [CNT_W-1:0]  cnt_arr [DEPTH];
  logic [IDX_W-1:0]  fill_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [DATA_W-1:0] val_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sel;
    assign sel = (idx_i == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
        cnt_q <= '0;
      end else if (clr_i) begin
        cnt_q <= '0;
      end else if (new_i && sel) begin
        val_q <= val_i;
        cnt_q <= CNT_W'(1);
      end else if (inc_i && sel) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
    assign val_arr[e] = val_q;
    assign cnt_arr[e] = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fill_q <= '0;
    else if (clr_i) fill_q <= '0;
    else if (new_i) fill_q <= fill_q + 1'b1;
  end

  always_comb begin
    rd_val_o = '0;
    rd_cnt_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (idx_i == IDX_W'(e)) begin
        rd_val_o = val_arr[e];
        rd_cnt_o = cnt_arr[e];
      end
    end
  end

  assign fill_o = fill_q;
endmodule

// File: rtl/mvf_tracker.sv
module mvf_tracker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              upd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] val_i,
  output logic [CNT_W-1:0]  max_cnt_o,
  output logic [DATA_W-1:0] max_val_o
);
  logic [CNT_W-1:0]  max_cnt_q;
  logic [DATA_W-1:0] max_val_q;

  // strict compare: on a tie the earlier holder stays
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_cnt_q <= '0;
      max_val_q <= '0;
    end else if (clr_i) begin
      max_cnt_q <= '0;
      max_val_q <= '0;
    end else if (upd_i && (cnt_i > max_cnt_q)) begin
      max_cnt_q <= cnt_i;
      max_val_q <= val_i;
    end
  end

  assign max_cnt_o = max_cnt_q;
  assign max_val_o = max_val_q;
endmodule

// File: rtl/maj_read_filter.sv
module maj_read_filter #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int SAMPLES = 100,
  parameter int DEPTH   = SAMPLES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              src_rd_o,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_valid_i
);
  import mvf_pkg::*;

  localparam int CNT_W = $clog2(SAMPLES + 1);
  localparam int IDX_W = $clog2(DEPTH + 1);
  localparam int HALF  = SAMPLES / 2;

  mvf_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] smp_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  scnt_q;

  logic              accept, in_search, hit, at_end, settle, last, early;
  logic [DATA_W-1:0] tbl_val;
  logic [CNT_W-1:0]  tbl_cnt, new_cnt, max_cnt;
  logic [IDX_W-1:0]  fill;
  logic [DATA_W-1:0] max_val;

  assign accept    = (state_q == ST_IDLE) && req_i;
  assign in_search = (state_q == ST_SEARCH);
  assign at_end    = (idx_q == fill);
  assign hit       = !at_end && (tbl_val == smp_q);
  assign settle    = in_search && (hit || at_end);
  assign new_cnt   = at_end ? CNT_W'(1) : tbl_cnt + 1'b1;
  assign last      = (scnt_q == CNT_W'(SAMPLES - 1));
  assign early     = (new_cnt > CNT_W'(HALF));

  mvf_table #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .new_i    (in_search && at_end),
    .inc_i    (in_search && hit),
    .idx_i    (idx_q),
    .val_i    (smp_q),
    .rd_val_o (tbl_val),
    .rd_cnt_o (tbl_cnt),
    .fill_o   (fill)
  );

  mvf_tracker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tracker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .upd_i     (settle),
    .cnt_i     (new_cnt),
    .val_i     (smp_q),
    .max_cnt_o (max_cnt),
    .max_val_o (max_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      smp_q   <= '0;
      idx_q   <= '0;
      scnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          addr_q  <= addr_i;
          scnt_q  <= '0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (src_valid_i) begin
          smp_q   <= src_data_i;
          idx_q   <= '0;
          state_q <= ST_SEARCH;
        end
        ST_SEARCH: begin
          if (settle) begin
            scnt_q  <= scnt_q + 1'b1;
            state_q <= (last || early) ? ST_DONE : ST_ISSUE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o     = (state_q == ST_DONE);
  assign data_o     = done_o ? max_val : '0;
  assign src_rd_o   = (state_q == ST_ISSUE);
  assign src_addr_o = addr_q;

  logic unused_max;
  assign unused_max = ^max_cnt;
endmodule

// File: rtl/mvf_checker.sv
module mvf_checker #(
  parameter int SAMPLES = 100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic done_i,
  input logic rd_i,
  input logic valid_i
);
  localparam int RC_W = $clog2(SAMPLES + 2);
  localparam int HALF = SAMPLES / 2;

  logic [RC_W-1:0] rd_cnt_q;
  logic            pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (done_i)    rd_cnt_q <= '0;
      else if (rd_i) rd_cnt_q <= rd_cnt_q + 1'b1;
      if (rd_i)         pend_q <= 1'b1;
      else if (valid_i) pend_q <= 1'b0;
    end
  end

  AST_RD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !rd_i); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !pend_q); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R7
  AST_READ_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt_q <= RC_W'(SAMPLES)); // R6
  AST_MIN_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> rd_cnt_q > RC_W'(HALF)); // R5
  AST_NO_RD_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !rd_i && !pend_q); // R7
endmodule

bind maj_read_filter mvf_checker #(.SAMPLES(SAMPLES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .done_i  (done_o),
  .rd_i    (src_rd_o),
  .valid_i (src_valid_i)
);

// File: tb/maj_read_filter_test.sv
module maj_read_filter_test;
  localparam int N = 100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        done_o;
  logic [31:0] data_o;
  logic        src_rd_o;
  logic [7:0]  src_addr_o;
  logic [31:0] src_data_i;
  logic        src_valid_i;

  maj_read_filter uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .done_o(done_o), .data_o(data_o), .src_rd_o(src_rd_o),
    .src_addr_o(src_addr_o), .src_data_i(src_data_i),
    .src_valid_i(src_valid_i)
  );

  always #2 clk_i = ~clk_i;

  typedef struct {
    logic [31:0] val;
    int          reads;
  } exp_t;

  exp_t        exp_q[$];
  string       tag_q[$];
  logic [31:0] pat [N];
  int          n_chk = 0, n_fail = 0, n_done = 0;
  int          src_n = 0, addr_err = 0;
  logic [7:0]  cur_addr = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // source model: answers one cycle after each read strobe
  initial begin
    bit pend = 0;
    int pidx = 0;
    src_valid_i = 1'b0;
    src_data_i  = '0;
    forever begin
      @(negedge clk_i);
      src_valid_i = pend;
      src_data_i  = pend ? pat[pidx] : 32'h0;
      pend = 0;
      if (src_rd_o) begin
        pend = 1;
        pidx = (src_n < N) ? src_n : N - 1;
        if (src_addr_o !== cur_addr) addr_err++;
        src_n++;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(0, "R8", "unexpected done", data_o, 32'h0);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(data_o === e.val, t, "result", data_o, e.val);
          check(src_n == e.reads, "R5/R6", "read count", src_n, e.reads);
          check(addr_err == 0, "R2", "read address mismatches", addr_err, 0);
        end
        n_done++;
      end
    end
  end

  task automatic expect_from_pat(output logic [31:0] v, output int reads);
    logic [31:0] vals [N];
    int          cnts [N];
    int          nv = 0, best = 0;
    v = '0;
    reads = N;
    for (int i = 0; i < N; i++) begin
      int j = 0;
      while (j < nv && vals[j] != pat[i]) j++;
      if (j == nv) begin vals[j] = pat[i]; cnts[j] = 0; nv++; end
      cnts[j]++;
      if (cnts[j] > best) begin best = cnts[j]; v = vals[j]; end
      if (best > N / 2) begin reads = i + 1; break; end
    end
  endtask

  task automatic run_txn(input string tag, input logic [7:0] a, input bit poke);
    exp_t e;
    int   prev;
    expect_from_pat(e.val, e.reads);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    prev = n_done;
    @(negedge clk_i);
    src_n = 0; addr_err = 0; cur_addr = a;
    req_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0; addr_i = 8'h00;
    if (poke) begin
      repeat (30) @(negedge clk_i);
      req_i = 1'b1; addr_i = 8'h5A;
      @(negedge clk_i);
      req_i = 1'b0; addr_i = 8'h00;
    end
    wait (n_done == prev + 1);
    @(negedge clk_i);
    check(!done_o && data_o == 0, "R7", "output after pulse", data_o, 32'h0);
    if (poke) begin
      int rd_before = src_n;
      repeat (300) @(negedge clk_i);
      check(n_done == prev + 1 && src_n == rd_before, "R8",
            "activity after dropped request", src_n, rd_before);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R2 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    req_i = 1'b1;  // held during reset, must be ignored
    repeat (3) @(negedge clk_i);
    check(!done_o, "R1", "done in reset", done_o, 0);
    check(!src_rd_o, "R1", "read in reset", src_rd_o, 0);
    req_i = 1'b0;
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(!src_rd_o && !done_o, "R1", "idle after reset", src_rd_o, 0);
    check(data_o == 0, "R1", "data after reset", data_o, 0);

    for (int i = 0; i < N; i++) pat[i] = 32'hCAFE_0001;
    run_txn("R5", 8'h10, 0);

    for (int i = 0; i < N; i++) pat[i] = 32'h0000_1000 + i * 7;
    run_txn("R4/R6", 8'h21, 0);

    for (int i = 0; i < N; i++) pat[i] = (i % 2 == 0) ? 32'hAAAA_0000 : 32'hBBBB_0000;
    run_txn("R4", 8'h32, 0);

    for (int i = 0; i < N; i++)
      pat[i] = (i % 4 == 1 || i % 4 == 2) ? 32'hBBBB_0000 : 32'hAAAA_0000;
    run_txn("R4 first-to-reach", 8'h43, 0);

    for (int i = 0; i < N; i++) pat[i] = (i % 2 == 0) ? 32'hAAAA_0000 : 32'hBBBB_0000;
    run_txn("R9", 8'h54, 0);

    for (int i = 0; i < N; i++) pat[i] = (i < 49) ? 32'h2000 + i : 32'h0000_BEEF;
    run_txn("R3/R6", 8'h65, 0);

    for (int i = 0; i < N; i++)
      pat[i] = (i % 4 == 3) ? 32'h1234_5678 + i : 32'h7777_0003;
    run_txn("R3/R5", 8'h76, 0);

    for (int i = 0; i < N; i++)
      pat[i] = (i % 3 == 0) ? 32'h0BAD_0000 + i : 32'h600D_0000 + (i % 3);
    run_txn("R3 R8", 8'h87, 1);

    check(exp_q.size() == 0, "R8", "pending results", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule